// File: doc/BRIEF.md
# Sequential-Load Palette DAC

This block is a 256-entry colour lookup table loaded through a 16-byte host register window. The host first writes an entry number to an index register. It then writes the red, green and blue components of that entry to a data register, one component per write. Once blue has been written, the index moves to the next entry, so a whole palette can be streamed in with a single index write followed by back-to-back data writes.

A second, independent port serves the pixel pipeline. Each cycle it takes an 8-bit pixel index and returns the 24-bit colour stored at that entry one cycle later. Host reads of the window always return zero. The table comes out of reset with every entry black except the last one, which is white.

Top module: `pal_dac`

## Requirements
- R1: After reset every table entry reads 24'h000000 on the lookup port, except entry 255, which reads 24'hFFFFFF. The component sequencer starts at red and the current index starts at 0.
- R2: A host write to byte offset 0x0 sets the current index to wdata_i[31:24] and returns the component sequencer to red, even if a red or green write has already been made.
- R3: Host writes to byte offset 0x4 take the component from wdata_i[31:24]. The first, second and third such writes after an index write load red, green and blue of the current entry. The lookup port presents an entry as {red[23:16], green[15:8], blue[7:0]}.
- R4: The blue write advances the current index by one, wrapping from 255 to 0, and the next data write loads red again.
- R5: Host writes to any offset other than 0x0 and 0x4 change neither the table, nor the index, nor the sequencer.
- R6: rdata_o reads zero at all times.
- R7: The lookup port is registered. pix_rgb_o shows the entry selected by pix_idx_i at the previous rising edge. A host write that updates an entry shows up on pix_rgb_o one cycle after the edge that performs the write.
- R8: wdata_i[23:0] has no effect on either index writes or data writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 4 | Host byte offset within the window |
| wdata_i | input | 32 | Host write data; only bits 31:24 are used |
| rdata_o | output | 32 | Host read data, always zero |
| pix_idx_i | input | 8 | Pixel lookup index |
| pix_rgb_o | output | 24 | Registered colour of the looked-up entry |

## Verification
The bench builds the block with its default parameters: 8-bit index, 8-bit components and a 4-bit byte offset. At that size every entry can be read back after reset and after a full load. The full load streams 768 data writes from one index write, which carries the index across the 255-to-0 wrap and leaves one extra red write landing on entry 0. Every offset in the 16-byte window can also be tried, and the one-cycle lookup latency is checked against a write made while the lookup index is held on the entry being written.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;
endpackage

// File: rtl/pal_dac_decode.sv
module pal_dac_decode #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned IDX_OFF  = 0,
  parameter int unsigned DATA_OFF = 4
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              idx_we_o,
  output logic              data_we_o
);
  localparam logic [ADDR_W-1:0] IdxOff  = ADDR_W'(IDX_OFF);
  localparam logic [ADDR_W-1:0] DataOff = ADDR_W'(DATA_OFF);

  // every other offset in the window falls through silently
  assign idx_we_o  = wr_en_i && (addr_i == IdxOff);
  assign data_we_o = wr_en_i && (addr_i == DataOff);
endmodule

// File: rtl/pal_dac_seq.sv
module pal_dac_seq
  import pal_dac_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_we_i,
  input  logic             data_we_i,
  input  logic [CW-1:0]    byte_i,
  output logic [IDX_W-1:0] cur_idx_o,
  output comp_e            comp_o,
  output logic [2:0]       wr_comp_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [CW-1:0]    wr_val_o
);
  logic [IDX_W-1:0] idx_q;
  comp_e            comp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      comp_q <= COMP_R;
    end else if (idx_we_i) begin
      idx_q  <= byte_i[IDX_W-1:0];
      comp_q <= COMP_R;
    end else if (data_we_i) begin
      unique case (comp_q)
        COMP_R:  comp_q <= COMP_G;
        COMP_G:  comp_q <= COMP_B;
        default: begin
          comp_q <= COMP_R;
          idx_q  <= idx_q + 1'b1;
        end
      endcase
    end
  end

  // wr_comp_o bit 2 = red, 1 = green, 0 = blue
  always_comb begin
    wr_comp_o = 3'b000;
    if (data_we_i) begin
      unique case (comp_q)
        COMP_R:  wr_comp_o = 3'b100;
        COMP_G:  wr_comp_o = 3'b010;
        default: wr_comp_o = 3'b001;
      endcase
    end
  end

  assign wr_idx_o  = idx_q;
  assign wr_val_o  = byte_i;
  assign cur_idx_o = idx_q;
  assign comp_o    = comp_q;
endmodule

// File: rtl/pal_dac_table.sv
module pal_dac_table #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        wr_comp_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CW-1:0]     wr_val_i,
  input  logic [IDX_W-1:0]  pix_idx_i,
  output logic [3*CW-1:0]   pix_rgb_o
);
  localparam int unsigned N  = 1 << IDX_W;
  localparam int unsigned EW = 3 * CW;

  logic [EW-1:0] ent_q [N];
  logic [EW-1:0] pix_q;

  for (genvar e = 0; e < N; e++) begin : g_ent
    localparam logic [EW-1:0] RstVal = (e == N - 1) ? {EW{1'b1}} : {EW{1'b0}};
    logic hit;
    assign hit = (wr_idx_i == IDX_W'(e));
    for (genvar c = 0; c < 3; c++) begin : g_comp
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          ent_q[e][c*CW +: CW] <= RstVal[c*CW +: CW];
        else if (hit && wr_comp_i[c])
          ent_q[e][c*CW +: CW] <= wr_val_i;
      end
    end
  end

  // registered lookup, independent of the host side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_q <= '0;
    else         pix_q <= ent_q[pix_idx_i];
  end

  assign pix_rgb_o = pix_q;
endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_dac_pkg::*;
#(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned CW       = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned IDX_OFF  = 0,
  parameter int unsigned DATA_OFF = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [IDX_W-1:0]  pix_idx_i,
  output logic [3*CW-1:0]   pix_rgb_o
);
  localparam int unsigned BYTE_LO = DW - CW;

  logic             idx_we, data_we;
  logic [IDX_W-1:0] cur_idx;
  comp_e            comp;
  logic [2:0]       wr_comp;
  logic [IDX_W-1:0] wr_idx;
  logic [CW-1:0]    wr_val;
  logic             unused_low;

  assign unused_low = ^wdata_i[BYTE_LO-1:0];
  assign rdata_o    = '0;

  pal_dac_decode #(
    .ADDR_W  (ADDR_W),
    .IDX_OFF (IDX_OFF),
    .DATA_OFF(DATA_OFF)
  ) u_decode (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .idx_we_o (idx_we),
    .data_we_o(data_we)
  );

  pal_dac_seq #(.IDX_W(IDX_W), .CW(CW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_we_i (idx_we),
    .data_we_i(data_we),
    .byte_i   (wdata_i[DW-1:BYTE_LO]),
    .cur_idx_o(cur_idx),
    .comp_o   (comp),
    .wr_comp_o(wr_comp),
    .wr_idx_o (wr_idx),
    .wr_val_o (wr_val)
  );

  pal_dac_table #(.IDX_W(IDX_W), .CW(CW)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_comp_i(wr_comp),
    .wr_idx_i (wr_idx),
    .wr_val_i (wr_val),
    .pix_idx_i(pix_idx_i),
    .pix_rgb_o(pix_rgb_o)
  );
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk
  import pal_dac_pkg::*;
#(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned IDX_OFF  = 0,
  parameter int unsigned DATA_OFF = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [IDX_W-1:0]  cur_idx,
  input comp_e             comp
);
  logic idx_hit, data_hit, other_hit;
  assign idx_hit   = wr_en_i && (addr_i == ADDR_W'(IDX_OFF));
  assign data_hit  = wr_en_i && (addr_i == ADDR_W'(DATA_OFF));
  assign other_hit = wr_en_i && !idx_hit && !data_hit;

  assert_index_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_hit |=> (cur_idx == $past(wdata_i[DW-1 -: IDX_W])) && (comp == COMP_R));

  assert_blue_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_hit && comp == COMP_B) |=> (cur_idx == $past(cur_idx) + 1'b1) && (comp == COMP_R));

  assert_comp_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_hit && comp != COMP_B) |=> $stable(cur_idx) && (comp != $past(comp)) && (comp != COMP_R));

  assert_other_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_hit |=> $stable(cur_idx) && $stable(comp));

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cur_idx) && $stable(comp));
endmodule

bind pal_dac pal_dac_chk #(
  .IDX_W   (IDX_W),
  .ADDR_W  (ADDR_W),
  .DW      (DW),
  .IDX_OFF (IDX_OFF),
  .DATA_OFF(DATA_OFF)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .cur_idx(cur_idx),
  .comp   (comp)
);

// File: tb/tb_pal_dac.sv
module tb_pal_dac;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  pix_idx_i = '0;
  logic [23:0] pix_rgb_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [23:0] m_tab [256];
  logic [7:0]  m_idx;
  int          m_comp;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pal_dac dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pix_idx_i(pix_idx_i), .pix_rgb_o(pix_rgb_o)
  );

  function automatic logic [7:0] pat(int i, int c);
    return 8'((i * 37 + c * 101 + 11) & 255);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // model per R2/R3/R4/R5/R8
  task automatic model_wr(logic [3:0] a, logic [31:0] d);
    if (a == 4'h0) begin
      m_idx  = d[31:24];
      m_comp = 0;
    end else if (a == 4'h4) begin
      m_tab[m_idx][23 - 8*m_comp -: 8] = d[31:24];
      if (m_comp == 2) begin
        m_comp = 0;
        m_idx  = m_idx + 8'd1;
      end else m_comp++;
    end
  endtask

  task automatic host_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    #1 check("R6 rdata during write", rdata_o, 32'h0);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model_wr(a, d);
  endtask

  task automatic lookup(string req, int idx);
    @(negedge clk_i);
    pix_idx_i = 8'(idx);
    @(negedge clk_i);
    check(req, {8'h0, pix_rgb_o}, {8'h0, m_tab[idx]});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_tab[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
    m_idx = 8'd0; m_comp = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset contents, R6 idle
    check("R6 rdata idle", rdata_o, 32'h0);
    for (int i = 0; i < 256; i++) lookup("R1 reset entry", i);

    // R1 sequencer at red, index 0: data write without index write
    host_wr(4'h4, {8'h3C, 24'h0});
    lookup("R1 first write hits entry 0 red", 0);
    host_wr(4'h0, {8'h00, 24'h0});
    host_wr(4'h4, {8'h00, 24'h0});

    // R3/R4/R8 full streamed load with garbage low bits, wraps index
    host_wr(4'h0, {8'h00, 24'h123456});
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++)
        host_wr(4'h4, {pat(i, c), 24'h5A5A5A ^ 24'(i * 3 + c)});
    for (int i = 0; i < 256; i++) lookup("R3 streamed entry", i);

    // R4 wrap: next data write lands on entry 0 red
    host_wr(4'h4, {8'hAA, 24'hFFFFFF});
    lookup("R4 wrap to entry 0", 0);
    check("R4 red after wrap", {24'h0, pix_rgb_o[23:16]}, 32'hAA);

    // R7 lookup latency while writing blue of entry 9
    host_wr(4'h0, {8'd9, 24'h0});
    host_wr(4'h4, {8'h11, 24'h0});
    host_wr(4'h4, {8'h22, 24'h0});
    @(negedge clk_i);
    pix_idx_i = 8'd9;
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 4'h4; wdata_i = {8'h33, 24'h0};
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R7 old value at write edge", {8'h0, pix_rgb_o}, {8'h0, 8'h11, 8'h22, pat(9, 2)});
    model_wr(4'h4, {8'h33, 24'h0});
    @(negedge clk_i);
    check("R7 new value one cycle later", {8'h0, pix_rgb_o}, 32'h00112233);

    // R2 index write restarts at red
    host_wr(4'h0, {8'd20, 24'hABCDEF});
    host_wr(4'h4, {8'h44, 24'h0});
    host_wr(4'h4, {8'h55, 24'h0});
    host_wr(4'h0, {8'd20, 24'h0});
    host_wr(4'h4, {8'h66, 24'h0});
    lookup("R2 red rewritten after index write", 20);
    check("R2 entry 20 value", {8'h0, pix_rgb_o}, {8'h0, 8'h66, 8'h55, pat(20, 2)});
    host_wr(4'h4, {8'h77, 24'h0});
    host_wr(4'h4, {8'h88, 24'h0});
    host_wr(4'h4, {8'h99, 24'h0});
    lookup("R4 advance to entry 21", 21);
    lookup("R3 entry 20 complete", 20);

    // R5 other offsets ignored
    for (int a = 0; a < 16; a++)
      if (a != 0 && a != 4) host_wr(4'(a), {8'hEE, 24'hEEEEEE});
    lookup("R5 entry 21 untouched", 21);
    lookup("R5 entry 238 untouched", 238);
    host_wr(4'h4, {8'hC1, 24'h0});
    lookup("R5 sequencer held at green", 21);
    check("R5 green of 21", {8'h0, pix_rgb_o}, {8'h0, 8'h99, 8'hC1, pat(21, 2)});

    // R8 index write low bits ignored
    host_wr(4'h0, {8'd200, 24'hFFFFFF});
    host_wr(4'h4, {8'h5E, 24'h0});
    lookup("R8 index from top byte", 200);

    check("R6 rdata final", rdata_o, 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule